// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block is a master that fetches one 16-bit word from a three-wire serial EEPROM. It drives chip select, serial clock and serial data-in pins, and it samples the memory's serial data-out pin. A host puts an 8-bit word address on `addr_i` and a hold count on `settle_i`, then pulses `start_i`. The controller then plays out a fixed sequence of 63 pin states. Each state stays on the pins for a programmable number of clock cycles, so that slow memories have time to settle. The sequence has these parts: a select preamble, a start bit, a 2-bit read opcode, eight address bits, a dummy cycle, sixteen data cycles, a trailing all-low cycle and a deselect postamble.

When the last state has been held for its full time, the block returns the assembled word on `word_o` and pulses `done_o` for one cycle. The serial clock is never free-running. Every edge on the pins is a separate step that the host can slow down by raising the hold count.

Top module: `uwire_word_reader`

## Requirements
- R1: While reset is applied, and right after it, `busy_o` and `done_o` are low, the pins `cs_o`, `sk_o` and `di_o` are low, and `word_o` is zero.
- R2: Each pin state is held for N clock cycles, where N is the value of `settle_i` captured when the start is accepted. A value of 0 gives N = 1. Changing `settle_i` during a transaction has no effect on it.
- R3: The transaction opens with four states, written as (cs, sk, di): (0,0,0), then (1,0,0), then (1,1,0), then (1,0,0).
- R4: Next come eleven command bits: a start bit of 1, the read opcode as the bits 1 then 0, and the address from bit 7 down to bit 0. Each bit takes two states: (1,0,bit) and then (1,1,bit).
- R5: After the last address bit there is one dummy state (1,0,0).
- R6: Sixteen data bits follow, MSB first. Each bit takes the state (1,1,0) and then the state (1,0,0). The data-out pin is sampled at the end of the second state and shifted into the LSB of the word.
- R7: After the data comes one all-low state. Then the postamble applies (1,0,0), then (0,0,0), then (0,1,0). The pins stay at (0,1,0) until the next accepted start.
- R8: A start is accepted only while `busy_o` is low. `busy_o` is high from the cycle after acceptance until the cycle in which `done_o` is high. A start pulse or an address change while busy has no effect on the pins or on the result.
- R9: `done_o` is a one-cycle pulse that comes when the 63rd state has been held for N cycles. `word_o` takes the new word in that same cycle and changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Read request strobe |
| addr_i | input | 8 | Word address, captured at an accepted start |
| settle_i | input | DLY_W | Cycles per pin state (0 means 1), captured at an accepted start |
| do_i | input | 1 | Serial data from the EEPROM |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| word_o | output | 16 | Last word read |
| cs_o | output | 1 | Chip select to the EEPROM |
| sk_o | output | 1 | Serial clock to the EEPROM |
| di_o | output | 1 | Serial data to the EEPROM |

## Verification
The hardest condition to reach is a disturbance in the middle of a transfer. The bench has to show that a new start strobe, a new address and a new hold count, all arriving while the block is busy, leave both the pin trace and the returned word untouched. To get there, the bench watches every state for its full hold time and, partway through the data phase, drives a start strobe with a different address. At acceptance it also swaps `settle_i` to a large value, so that any re-capture would stretch the trace it compares against. A behavioural memory model in the bench decodes the command from the pins and answers with an address-dependent word, which makes a wrong bit order or a wrong sample point show up in the returned value.

// File: rtl/uwr_pkg.sv
package uwr_pkg;

    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 16;
    localparam int OP_W       = 2;
    localparam logic [OP_W-1:0] OP_READ = 2'b10;

    localparam int PRE_STEPS  = 4;
    localparam int CMD_BITS   = 1 + OP_W + ADDR_W;
    localparam int CMD_STEPS  = 2 * CMD_BITS;
    localparam int DATA_STEPS = 2 * DATA_W;
    localparam int POST_STEPS = 3;

    localparam int CMD_BASE   = PRE_STEPS;
    localparam int DUMMY_STEP = CMD_BASE + CMD_STEPS;
    localparam int DATA_BASE  = DUMMY_STEP + 1;
    localparam int TRAIL_STEP = DATA_BASE + DATA_STEPS;
    localparam int POST_BASE  = TRAIL_STEP + 1;
    localparam int NUM_STEPS  = POST_BASE + POST_STEPS;
    localparam int STEP_W     = $clog2(NUM_STEPS);

    typedef logic [STEP_W-1:0] step_t;

    localparam step_t LAST_STEP = step_t'(NUM_STEPS - 1);

    typedef struct packed {
        logic cs;
        logic sk;
        logic di;
    } pins_t;

endpackage

// File: rtl/uwr_step_timer.sv
module uwr_step_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [DLY_W-1:0] len_i,
    output logic             end_o
);

    typedef struct packed {
        logic [DLY_W-1:0] len;
        logic [DLY_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    assign end_o = run_i && (t_q.cnt == t_q.len - 1'b1);

    always_comb begin
        t_d = t_q;
        if (load_i) begin
            t_d.len = (len_i == '0) ? DLY_W'(1) : len_i;
            t_d.cnt = '0;
        end else if (run_i) begin
            if (end_o) begin
                t_d.cnt = '0;
            end else begin
                t_d.cnt = t_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.len <= DLY_W'(1);
            t_q.cnt <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    // R2: the hold counter never runs past the captured length
    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (t_q.cnt < t_q.len));

    // R2: a captured length is never zero
    p_len_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.len != '0);

endmodule

// File: rtl/uwr_wave_gen.sv
module uwr_wave_gen
    import uwr_pkg::*;
(
    input  step_t               step_i,
    input  logic [ADDR_W-1:0]   addr_i,
    output pins_t               pins_o,
    output logic                sample_o
);

    logic [CMD_BITS-1:0] cmd_word;
    logic [CMD_BITS-1:0] cmd_shift;
    step_t               rel;

    assign cmd_word = {1'b1, OP_READ, addr_i};

    always_comb begin
        pins_o    = '0;
        sample_o  = 1'b0;
        rel       = '0;
        cmd_shift = '0;
        if (step_i < step_t'(CMD_BASE)) begin
            // select preamble
            case (step_i[1:0])
                2'd0:    pins_o = '{cs: 1'b0, sk: 1'b0, di: 1'b0};
                2'd1:    pins_o = '{cs: 1'b1, sk: 1'b0, di: 1'b0};
                2'd2:    pins_o = '{cs: 1'b1, sk: 1'b1, di: 1'b0};
                default: pins_o = '{cs: 1'b1, sk: 1'b0, di: 1'b0};
            endcase
        end else if (step_i < step_t'(DUMMY_STEP)) begin
            // command bits, two steps each
            rel       = step_i - step_t'(CMD_BASE);
            cmd_shift = cmd_word << rel[STEP_W-1:1];
            pins_o.cs = 1'b1;
            pins_o.sk = rel[0];
            pins_o.di = cmd_shift[CMD_BITS-1];
        end else if (step_i == step_t'(DUMMY_STEP)) begin
            pins_o = '{cs: 1'b1, sk: 1'b0, di: 1'b0};
        end else if (step_i < step_t'(TRAIL_STEP)) begin
            // data bits: clock high, then clock low and sample
            rel       = step_i - step_t'(DATA_BASE);
            pins_o.cs = 1'b1;
            pins_o.sk = ~rel[0];
            pins_o.di = 1'b0;
            sample_o  = rel[0];
        end else if (step_i == step_t'(TRAIL_STEP)) begin
            pins_o = '0;
        end else begin
            // deselect postamble
            rel = step_i - step_t'(POST_BASE);
            case (rel[1:0])
                2'd0:    pins_o = '{cs: 1'b1, sk: 1'b0, di: 1'b0};
                2'd1:    pins_o = '{cs: 1'b0, sk: 1'b0, di: 1'b0};
                default: pins_o = '{cs: 1'b0, sk: 1'b1, di: 1'b0};
            endcase
        end
    end

endmodule

// File: rtl/uwr_shift_in.sv
module uwr_shift_in #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);

    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (clear_i) begin
            sh_d = '0;
        end else if (shift_i) begin
            sh_d = {sh_q[W-2:0], bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign word_o = sh_q;

    // R6: a new transaction never starts in the same cycle as a data sample
    p_clear_vs_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(clear_i && shift_i));

endmodule

// File: rtl/uwire_word_reader.sv
module uwire_word_reader
    import uwr_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        addr_i,
    input  logic [DLY_W-1:0]  settle_i,
    input  logic              do_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [15:0]       word_o,
    output logic              cs_o,
    output logic              sk_o,
    output logic              di_o
);

    typedef struct packed {
        logic              busy;
        logic              done;
        step_t             step;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] word;
    } ctl_t;

    ctl_t              c_d, c_q;
    pins_t             pins_d, pins_q;
    pins_t             wave_pins;
    logic              wave_sample;
    logic              sample_d, sample_q;
    logic              accept;
    logic              step_end;
    logic              shift_en;
    logic [DATA_W-1:0] shift_word;

    assign accept   = !c_q.busy && start_i;
    assign shift_en = c_q.busy && step_end && sample_q;

    uwr_step_timer #(.DLY_W(DLY_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .run_i  (c_q.busy),
        .len_i  (settle_i),
        .end_o  (step_end)
    );

    uwr_wave_gen u_wave (
        .step_i   (c_d.step),
        .addr_i   (c_d.addr),
        .pins_o   (wave_pins),
        .sample_o (wave_sample)
    );

    uwr_shift_in #(.W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .shift_i (shift_en),
        .bit_i   (do_i),
        .word_o  (shift_word)
    );

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        if (accept) begin
            c_d.busy = 1'b1;
            c_d.step = '0;
            c_d.addr = addr_i;
        end else if (c_q.busy && step_end) begin
            if (c_q.step == LAST_STEP) begin
                c_d.busy = 1'b0;
                c_d.done = 1'b1;
                c_d.word = shift_word;
            end else begin
                c_d.step = c_q.step + 1'b1;
            end
        end
        pins_d   = c_d.busy ? wave_pins : pins_q;
        sample_d = c_d.busy && wave_sample;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q      <= '0;
            pins_q   <= '0;
            sample_q <= 1'b0;
        end else begin
            c_q      <= c_d;
            pins_q   <= pins_d;
            sample_q <= sample_d;
        end
    end

    assign busy_o = c_q.busy;
    assign done_o = c_q.done;
    assign word_o = c_q.word;
    assign cs_o   = pins_q.cs;
    assign sk_o   = pins_q.sk;
    assign di_o   = pins_q.di;

    // R9: completion is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.done |=> !c_q.done);

    // R9: the result moves only together with the completion pulse
    p_word_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(c_q.word) |-> c_q.done);

    // R8: busy and done never overlap
    p_busy_excl_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.busy |-> !c_q.done);

    // R8: the captured address is frozen for the whole transaction
    p_addr_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.busy && $past(c_q.busy)) |-> $stable(c_q.addr));

    // R6: sampling happens only with select high and clock low
    p_sample_pins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_q |-> (pins_q.cs && !pins_q.sk));

    // R7: idle pins hold their last state until a start arrives
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_q.busy && !start_i) |=> $stable(pins_q));

endmodule

// File: tb/uwire_word_reader_test.sv
`timescale 1ns/1ps
module uwire_word_reader_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  settle = '0;
    logic        eep_do = 1'b0;
    logic        busy, done, cs, sk, di;
    logic [15:0] word;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    uwire_word_reader uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .addr_i   (addr),
        .settle_i (settle),
        .do_i     (eep_do),
        .busy_o   (busy),
        .done_o   (done),
        .word_o   (word),
        .cs_o     (cs),
        .sk_o     (sk),
        .di_o     (di)
    );

    // behavioural memory: content of address a is {a, ~a}
    bit          m_started = 1'b0;
    bit          m_reading = 1'b0;
    int          m_nb = 0;
    int          m_didx = 0;
    logic [10:0] m_rx = '0;
    logic [10:0] m_last_cmd = '0;
    logic [15:0] m_word = '0;

    always @(negedge cs) begin
        m_started = 1'b0;
        m_reading = 1'b0;
    end

    always @(posedge sk) begin
        if (cs) begin
            if (m_reading) begin
                if (m_didx < 16) eep_do <= m_word[15 - m_didx];
                m_didx++;
            end else if (!m_started) begin
                if (di) begin
                    m_started = 1'b1;
                    m_nb = 1;
                    m_rx = 11'd1;
                end
            end else begin
                m_rx = {m_rx[9:0], di};
                m_nb++;
                if (m_nb == 11) begin
                    m_reading  = 1'b1;
                    m_last_cmd = m_rx;
                    m_word     = {m_rx[7:0], ~m_rx[7:0]};
                    m_didx     = 0;
                    eep_do    <= 1'b0;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // expected {cs,sk,di} for step k of a read of address a
    function automatic logic [2:0] exp_pins(input int k, input logic [7:0] a);
        logic [10:0] c;
        int r;
        c = {1'b1, 2'b10, a};
        if (k < 4) begin
            case (k)
                0: return 3'b000;
                1: return 3'b100;
                2: return 3'b110;
                default: return 3'b100;
            endcase
        end else if (k < 26) begin
            r = k - 4;
            return {1'b1, ((r % 2) == 1), c[10 - r / 2]};
        end else if (k == 26) begin
            return 3'b100;
        end else if (k < 59) begin
            r = k - 27;
            return ((r % 2) == 0) ? 3'b110 : 3'b100;
        end else if (k == 59) begin
            return 3'b000;
        end else if (k == 60) begin
            return 3'b100;
        end else if (k == 61) begin
            return 3'b000;
        end
        return 3'b010;
    endfunction

    task automatic run_read(input logic [7:0] a, input logic [7:0] dly,
                            input logic [15:0] exp_word, input bit inject,
                            input bit chk_prev, input logic [15:0] prev_word);
        int d;
        bit trace_ok;
        bit flags_ok;
        logic [2:0] act_bad;
        logic [2:0] exp_bad;
        d = (dly == 0) ? 1 : int'(dly);
        trace_ok = 1'b1;
        flags_ok = 1'b1;
        act_bad = '0;
        exp_bad = '0;
        @(negedge clk);
        addr   = a;
        settle = dly;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        settle = 8'hFF;      // R2: must not change the running hold time
        addr   = ~a;         // R8: must not change the running address
        for (int k = 0; k < 63; k++) begin
            for (int j = 0; j < d; j++) begin
                start = inject && (k == 30) && (j == 0);
                if ({cs, sk, di} !== exp_pins(k, a) && trace_ok) begin
                    trace_ok = 1'b0;
                    act_bad  = {cs, sk, di};
                    exp_bad  = exp_pins(k, a);
                    $display("  trace mismatch at step %0d cycle %0d", k, j);
                end
                if (busy !== 1'b1 || done !== 1'b0) flags_ok = 1'b0;
                if (chk_prev && k == 40 && j == 0)
                    chk(word === prev_word, "R9", "result held during next read", word, prev_word);
                @(negedge clk);
            end
        end
        start = 1'b0;
        chk(trace_ok, "R2 R3 R4 R5 R6 R7", "pin trace", act_bad, exp_bad);
        chk(flags_ok, "R8", "busy high and done low across transfer", 0, 1);
        chk(busy === 1'b0, "R8", "busy drops with done", busy, 0);
        chk(done === 1'b1, "R9", "done after last held state", done, 1);
        chk(word === exp_word, "R6", "returned word", word, exp_word);
        chk(m_last_cmd === {3'b110, a}, "R4", "command decoded by memory", m_last_cmd, {3'b110, a});
        @(negedge clk);
        chk(done === 1'b0, "R9", "done is one cycle", done, 0);
        chk({cs, sk, di} === 3'b010, "R7", "idle pins after postamble", {cs, sk, di}, 3'b010);
        chk(word === exp_word, "R9", "result stable after done", word, exp_word);
    endtask

    // {addr, settle, expected word}
    localparam logic [31:0] VEC [5] = '{
        {8'h00, 8'd0, 16'h00FF},
        {8'hFF, 8'd1, 16'hFF00},
        {8'hA5, 8'd3, 16'hA55A},
        {8'h3C, 8'd2, 16'h3CC3},
        {8'h01, 8'd5, 16'h01FE}
    };

    initial begin
        logic [15:0] prev;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy === 1'b0 && done === 1'b0, "R1", "flags in reset", {busy, done}, 0);
        chk({cs, sk, di} === 3'b000, "R1", "pins in reset", {cs, sk, di}, 0);
        chk(word === 16'h0, "R1", "word in reset", word, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy === 1'b0 && {cs, sk, di} === 3'b000, "R1", "idle after reset", {busy, cs, sk, di}, 0);

        prev = '0;
        for (int i = 0; i < 5; i++) begin
            run_read(VEC[i][31:24], VEC[i][23:16], VEC[i][15:0],
                     (i == 2), (i > 0), prev);
            prev = VEC[i][15:0];
        end

        // R8: injected start on a longer hold, with a high address bit
        run_read(8'h80, 8'd9, 16'h807F, 1'b1, 1'b1, prev);
        prev = 16'h807F;

        // R2: zero hold back to back right after a completion
        run_read(8'h5A, 8'd0, 16'h5AA5, 1'b0, 1'b1, prev);

        // R7: idle pins stay put with no start
        repeat (5) @(negedge clk);
        chk({cs, sk, di} === 3'b010 && busy === 1'b0, "R7", "pins held while idle", {busy, cs, sk, di}, 3'b010);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R8 run did not complete actual=%0h expected=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule